// File: doc/BRIEF.md
# Counter Read Permission Guard

This block decides, in one combinational step, what a read of a user-level counter CSR does. It looks at the 12-bit CSR address and, for any counter address, returns one of three outcomes: the access goes ahead, it raises an illegal-instruction fault, or it raises a virtual-instruction fault.

The outcome depends on four things:
- whether the counters extension is switched on;
- whether the hart is running virtualized;
- whether the current register width is 32 or 64 bits;
- the per-counter bits in the machine-level and hypervisor-level counter-enable registers.

The CSR unit of a core places this guard beside its read mux and uses the fault code to squash the access and pick the trap cause. Addresses that are not counters pass through with no fault. Those addresses are left to other checkers.

The counter family is laid out as follows:
- cycle, time and instret at 0xC00, 0xC01 and 0xC02;
- the hardware performance counters 3 to 31 at 0xC03 to 0xC1F;
- the upper halves of all of these at the same offsets above 0xC80.

The low five address bits form the counter index i. Bit i of each enable register belongs to that counter: bit 0 is cycle, bit 1 is time and bit 2 is instret.

Top module: `ctr_access_guard`

## Requirements
- R1: With the extension flag low, every address in 0xC00–0xC1F, and every address in 0xC80–0xC9F while in 32-bit mode, yields code 2'b01 (illegal instruction).
- R2: With the extension on, virtualization active and an address in 0xC00–0xC1F, the code is 2'b10 (virtual-instruction fault) when hypervisor enable bit i is 0 and machine enable bit i is 1, where i = address[4:0].
- R3: With the extension on and virtualization active, a counter access in the legal width gives 2'b00 whenever hypervisor bit i is 1 or machine bit i is 0.
- R4: In 32-bit mode (mode flag high), an upper-half address 0xC80–0xC9F follows the same rules as R1, R2 and R3, using bit i of its lower-half counterpart, with i = address[4:0].
- R5: An upper-half address 0xC80–0xC9F accessed in 64-bit mode (mode flag low) yields 2'b01, whatever the other inputs are.
- R6: With virtualization inactive and the extension on, a counter access in the legal width yields 2'b00, whatever the enable registers hold.
- R7: Any address outside 0xC00–0xC1F and 0xC80–0xC9F yields 2'b00.
- R8: The code 2'b11 never appears on the fault output.
- R9: Only bit i of each enable register affects the outcome. The other 31 bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | CSR address of the read being checked |
| ext_enable | input | 1 | Counters extension switched on |
| virt_active | input | 1 | Hart currently running virtualized |
| mode_rv32 | input | 1 | 1 = 32-bit register width, 0 = 64-bit |
| m_cnt_en | input | 32 | Machine-level counter-enable register |
| h_cnt_en | input | 32 | Hypervisor-level counter-enable register |
| fault_code | output | 2 | 00 none, 01 illegal instruction, 10 virtual-instruction fault |

## Verification
The hardest case to reach from the ports is a wrong index: a datapath that reads a neighbouring enable bit, or one that ignores the upper-half offset. It gives correct codes whenever the enable registers are uniform. To expose it, the sweep gives the selected bit i one value and every other bit the opposite value, for each of the four hypervisor and machine combinations. It does this at every address in 0xC00–0xCFF under all eight combinations of the extension, virtualization and width flags. A wrong index or a wrong offset then changes the expected code.

// File: rtl/ctr_guard_pkg.sv
package ctr_guard_pkg;

    localparam int unsigned CSR_ADDR_W = 12;
    localparam int unsigned NUM_CTR    = 32;
    localparam int unsigned CTR_IDX_W  = $clog2(NUM_CTR);

    localparam logic [CSR_ADDR_W-1:0] LO_BASE   = 12'hC00;
    localparam logic [CSR_ADDR_W-1:0] HI_OFFSET = 12'h080;
    localparam logic [CSR_ADDR_W-1:0] HI_BASE   = LO_BASE + HI_OFFSET;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ILLEGAL = 2'b01,
        FLT_VIRTUAL = 2'b10
    } fault_e;

    typedef struct packed {
        logic                 hit;
        logic                 upper;
        logic [CTR_IDX_W-1:0] idx;
    } ctr_sel_t;

    typedef struct packed {
        logic m_bit;
        logic h_bit;
    } en_pair_t;

    // Outcome rules: width gate, then extension gate, then two-level enable.
    function automatic fault_e resolve_fault(
        input ctr_sel_t sel,
        input logic     ext_on,
        input logic     virt_on,
        input logic     rv32,
        input en_pair_t en
    );
        fault_e res;
        res = FLT_NONE;
        if (sel.hit) begin
            if (sel.upper && !rv32) begin
                res = FLT_ILLEGAL;
            end else if (!ext_on) begin
                res = FLT_ILLEGAL;
            end else if (virt_on && !en.h_bit && en.m_bit) begin
                res = FLT_VIRTUAL;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = CSR_ADDR_W,
    parameter int unsigned N_CTR  = NUM_CTR
) (
    input  logic [ADDR_W-1:0] addr,
    output ctr_sel_t          sel
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(N_CTR);

    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;
    logic              in_lo;
    logic              in_hi;

    always_comb begin
        lo_off = addr - LO_BASE;
        hi_off = addr - HI_BASE;
        in_lo  = (addr >= LO_BASE) && (lo_off < SPAN);
        in_hi  = (addr >= HI_BASE) && (hi_off < SPAN);
        sel.hit   = in_lo || in_hi;
        sel.upper = in_hi;
        sel.idx   = in_hi ? hi_off[CTR_IDX_W-1:0] : lo_off[CTR_IDX_W-1:0];
    end
endmodule

// File: rtl/ctr_enable_pick.sv
module ctr_enable_pick
    import ctr_guard_pkg::*;
#(
    parameter int unsigned N_CTR = NUM_CTR
) (
    input  logic [CTR_IDX_W-1:0] idx,
    input  logic [N_CTR-1:0]     m_en,
    input  logic [N_CTR-1:0]     h_en,
    output en_pair_t             pick
);
    logic [N_CTR-1:0] onehot;
    logic [N_CTR-1:0] m_hit;
    logic [N_CTR-1:0] h_hit;

    for (genvar k = 0; k < N_CTR; k++) begin : g_slot
        assign onehot[k] = (idx == CTR_IDX_W'(k));
        assign m_hit[k]  = onehot[k] & m_en[k];
        assign h_hit[k]  = onehot[k] & h_en[k];
    end

    assign pick.m_bit = |m_hit;
    assign pick.h_bit = |h_hit;
endmodule

// File: rtl/ctr_fault_resolve.sv
module ctr_fault_resolve
    import ctr_guard_pkg::*;
(
    input  ctr_sel_t sel,
    input  logic     ext_on,
    input  logic     virt_on,
    input  logic     rv32,
    input  en_pair_t en,
    output fault_e   fault
);
    always_comb begin
        fault = resolve_fault(sel, ext_on, virt_on, rv32, en);
    end
endmodule

// File: rtl/ctr_access_guard.sv
module ctr_access_guard
    import ctr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W = CSR_ADDR_W,
    parameter int unsigned N_CTR  = NUM_CTR
) (
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              ext_enable,
    input  logic              virt_active,
    input  logic              mode_rv32,
    input  logic [N_CTR-1:0]  m_cnt_en,
    input  logic [N_CTR-1:0]  h_cnt_en,
    output logic [1:0]        fault_code
);
    ctr_sel_t sel;
    en_pair_t en;
    fault_e   fault;

    ctr_addr_decode #(.ADDR_W(ADDR_W), .N_CTR(N_CTR)) u_decode (
        .addr (csr_addr),
        .sel  (sel)
    );

    ctr_enable_pick #(.N_CTR(N_CTR)) u_pick (
        .idx  (sel.idx),
        .m_en (m_cnt_en),
        .h_en (h_cnt_en),
        .pick (en)
    );

    ctr_fault_resolve u_resolve (
        .sel     (sel),
        .ext_on  (ext_enable),
        .virt_on (virt_active),
        .rv32    (mode_rv32),
        .en      (en),
        .fault   (fault)
    );

    assign fault_code = fault;
endmodule

// File: rtl/ctr_access_guard_sva.sv
module ctr_access_guard_sva (
    input logic [11:0] csr_addr,
    input logic        ext_enable,
    input logic        virt_active,
    input logic        mode_rv32,
    input logic [31:0] m_cnt_en,
    input logic [31:0] h_cnt_en,
    input logic [1:0]  fault_code
);
    logic       is_ctr;
    logic       is_up;
    logic [4:0] ix;
    logic       width_ok;

    always_comb begin
        is_ctr   = (csr_addr & 12'hF60) == 12'hC00;
        is_up    = csr_addr[7];
        ix       = csr_addr[4:0];
        width_ok = !is_up || mode_rv32;

        assert_ext_off_illegal_R1 : assert (!(is_ctr && width_ok && !ext_enable) || fault_code == 2'b01);
        assert_virt_fault_R2 : assert (!(is_ctr && width_ok && ext_enable && virt_active
                                         && !h_cnt_en[ix] && m_cnt_en[ix]) || fault_code == 2'b10);
        assert_virt_pass_R3 : assert (!(is_ctr && width_ok && ext_enable && virt_active
                                        && (h_cnt_en[ix] || !m_cnt_en[ix])) || fault_code == 2'b00);
        assert_upper_wide_illegal_R5 : assert (!(is_ctr && is_up && !mode_rv32) || fault_code == 2'b01);
        assert_host_pass_R6 : assert (!(is_ctr && width_ok && ext_enable && !virt_active) || fault_code == 2'b00);
        assert_non_counter_R7 : assert (is_ctr || fault_code == 2'b00);
        assert_code_legal_R8 : assert (fault_code != 2'b11);
    end
endmodule

bind ctr_access_guard ctr_access_guard_sva sva_i (
    .csr_addr    (csr_addr),
    .ext_enable  (ext_enable),
    .virt_active (virt_active),
    .mode_rv32   (mode_rv32),
    .m_cnt_en    (m_cnt_en),
    .h_cnt_en    (h_cnt_en),
    .fault_code  (fault_code)
);

// File: tb/ctr_access_guard_tb_top.sv
`timescale 1ns/1ps
module ctr_access_guard_tb_top;
    logic        clk = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        ext_enable = 1'b0;
    logic        virt_active = 1'b0;
    logic        mode_rv32 = 1'b0;
    logic [31:0] m_cnt_en = '0;
    logic [31:0] h_cnt_en = '0;
    logic [1:0]  fault_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ctr_access_guard dut_i (
        .csr_addr    (csr_addr),
        .ext_enable  (ext_enable),
        .virt_active (virt_active),
        .mode_rv32   (mode_rv32),
        .m_cnt_en    (m_cnt_en),
        .h_cnt_en    (h_cnt_en),
        .fault_code  (fault_code)
    );

    task automatic apply_and_check(input logic [11:0] a, input logic ext, input logic virt,
                                   input logic r32, input logic [31:0] m, input logic [31:0] h);
        logic [1:0] exp;
        string      tag;
        logic       ctr;
        logic       up;
        int         i;
        @(negedge clk);
        csr_addr = a; ext_enable = ext; virt_active = virt; mode_rv32 = r32;
        m_cnt_en = m; h_cnt_en = h;
        #1;
        ctr = (a[11:8] == 4'hC) && (a[6:5] == 2'b00);
        up  = a[7];
        i   = int'(a[4:0]);
        if (!ctr) begin
            exp = 2'b00; tag = "R7";
        end else if (up && !r32) begin
            exp = 2'b01; tag = "R5";
        end else if (!ext) begin
            exp = 2'b01; tag = up ? "R1/R4" : "R1";
        end else if (!virt) begin
            exp = 2'b00; tag = "R6";
        end else if (!h[i] && m[i]) begin
            exp = 2'b10; tag = up ? "R2/R4/R9" : "R2/R9";
        end else begin
            exp = 2'b00; tag = up ? "R3/R4/R9" : "R3/R9";
        end
        n_run++;
        if (fault_code !== exp || fault_code === 2'b11) begin
            n_fail++;
            $display("FAIL %s (R8 legal code) addr=%h ext=%0b virt=%0b rv32=%0b: got %b expected %b",
                     tag, a, ext, virt, r32, fault_code, exp);
        end
    endtask

    initial begin : stim
        // Idle inputs: non-counter address 0, code none (R7)
        apply_and_check(12'h000, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        // Exhaustive sweep over 0xC00..0xCFF, all flag combos, isolated enable bit patterns (R1-R6, R9)
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 8; f++) begin
                for (int e = 0; e < 4; e++) begin
                    logic [31:0] sel_bit;
                    logic [31:0] mv;
                    logic [31:0] hv;
                    sel_bit = 32'h1 << (a % 32);
                    mv = e[0] ? sel_bit : ~sel_bit;
                    hv = e[1] ? sel_bit : ~sel_bit;
                    apply_and_check(12'hC00 + 12'(a), f[0] ? 1'b1 : 1'b0, f[1] ? 1'b1 : 1'b0,
                                    f[2] ? 1'b1 : 1'b0, mv, hv);
                end
            end
        end
        // Addresses outside the counter windows (R7)
        for (int k = 0; k < 8; k++) begin
            logic [11:0] outs [8];
            outs = '{12'h000, 12'h300, 12'hB00, 12'hBFF, 12'hD00, 12'h400, 12'hFFF, 12'h7A0};
            for (int f = 0; f < 8; f++) begin
                apply_and_check(outs[k], f[0] ? 1'b1 : 1'b0, f[1] ? 1'b1 : 1'b0,
                                f[2] ? 1'b1 : 1'b0, 32'h0, 32'hFFFF_FFFF);
                apply_and_check(outs[k], f[0] ? 1'b1 : 1'b0, f[1] ? 1'b1 : 1'b0,
                                f[2] ? 1'b1 : 1'b0, 32'hFFFF_FFFF, 32'h0);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule